// File: doc/BRIEF.md
# Serial Audio DAC Word Transmitter

This block sits between a parallel sample source and an external audio digital-to-analog converter that takes its input over three wires. Samples arrive as parallel words through a valid/ready handshake. Each accepted word is shifted onto a serial data line, most significant bit first. A bit clock runs alongside the data, and the receiver samples the data on the clock's rising edges. After the final bit, an active-low latch strobe tells the converter to take the word it has just received.

The frame length is chosen at run time. In the wide setting the block sends 18 bits, taken from the low 18 bits of the input bus. In the narrow setting it sends 16 bits, taken from the low 16 bits. Four configuration counts, all in system clock cycles, set how long the bit clock stays high, how long it stays low between bits, how long data is held before the first rising edge, and how long the latch gap and the latch pulse last. Each count is raised to a parameterised floor, so a small or zero setting cannot break the converter's minimum timing. With a 20 ns system clock, the default floors give at least 40 ns high, 40 ns low, 20 ns setup and 40 ns latch. The mode and the counts are captured when a word is accepted and hold for that whole frame.

Top module: `dac_word_tx`

## Requirements
- R1: The bits captured at successive rising edges of `serClk` within one frame, read in order, equal the transmitted word with its most significant bit first.
- R2: When `wideMode` is 1 at acceptance, the frame has exactly 18 rising edges of `serClk` and carries `inData[17:0]`.
- R3: When `wideMode` is 0 at acceptance, the frame has exactly 16 rising edges and carries `inData[15:0]`. Bits 17:16 of `inData` have no effect on the line.
- R4: `serData` does not change while `serClk` is high. It changes only in the cycle in which `serClk` falls, or in the first cycle after acceptance.
- R5: Every rising edge of `serClk` is preceded by at least S cycles of stable `serData` with `serClk` low, where S = max(`cfgSetup`, MIN_SETUP). The first bit is held for exactly S cycles before its rising edge.
- R6: Every high phase of `serClk` lasts exactly max(`cfgHigh`, MIN_HIGH) cycles.
- R7: Every low phase between two bits of a frame lasts exactly max(`cfgLow`, MIN_LOW, S) cycles.
- R8: After the last falling edge of a frame, `serClk` stays low and `serLatchN` stays high for exactly L = max(`cfgLatch`, MIN_LATCH) cycles before `serLatchN` falls.
- R9: `serLatchN` stays low for exactly L cycles, and `serClk` is low throughout that time.
- R10: `inReady` is 1 only while idle and 0 from acceptance until the latch pulse ends. A word is accepted on a rising edge of `clk` where `inValid` and `inReady` are both 1. `inReady` is 1 again in the cycle in which `serLatchN` returns high.
- R11: During reset and when idle, `serLatchN` is 1, `serClk` is 0 and `inReady` is 1. After reset `serData` is 0.
- R12: `wideMode` and all `cfg*` counts are sampled at acceptance. Changes made while a frame is in flight do not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wideMode | input | 1 | 1 selects 18-bit frames, 0 selects 16-bit frames |
| cfgHigh | input | CNT_W | Requested bit-clock high time in cycles |
| cfgLow | input | CNT_W | Requested bit-clock low time between bits in cycles |
| cfgSetup | input | CNT_W | Requested data setup before the first rising edge, in cycles |
| cfgLatch | input | CNT_W | Requested latch gap and latch pulse length in cycles |
| inValid | input | 1 | Upstream word valid |
| inReady | output | 1 | Block can accept a word |
| inData | input | DATA_W | Sample word, right-justified |
| serData | output | 1 | Serial data line |
| serClk | output | 1 | Bit clock, idles low |
| serLatchN | output | 1 | Latch strobe, active low, idles high |

## Verification
The bench watches the three serial wires and rebuilds each frame from them. It then compares the bit count, bit order and every phase length with values it computes from the counts in force at acceptance.

It targets several specific corner cases:
- Counts of zero, below the floors, must be clamped. A design missing the clamp would produce zero-length or wrapped phases.
- A setup count larger than the low count must stretch the low phase. A design ignoring this would give the later bits too little setup.
- In narrow mode, junk in the two upper bus bits would appear on the line if the frame were not left-justified correctly.
- The mode and counts are scrambled right after acceptance. A design that reads them live would change phase lengths mid-frame.
- Off-by-one errors in the bit counter show up as 15, 17 or 19 rising edges. Shifting on the wrong edge shows up as data moving while the clock is high.

// File: rtl/dac_tx_pkg.sv
package dac_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_GAP,
    ST_LATCH
  } txState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture word, mode and timing
    logic shift;  // advance to next bit
  } dpStrobe_t;

endpackage

// File: rtl/dac_tx_dp.sv
module dac_tx_dp
  import dac_tx_pkg::*;
#(
  parameter int DATA_W    = 18,
  parameter int NARROW_W  = 16,
  parameter int CNT_W     = 8,
  parameter int BIT_W     = 5,
  parameter int MIN_HIGH  = 2,
  parameter int MIN_LOW   = 2,
  parameter int MIN_SETUP = 1,
  parameter int MIN_LATCH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              wideMode,
  input  logic [DATA_W-1:0] inData,
  input  logic [CNT_W-1:0]  cfgHigh,
  input  logic [CNT_W-1:0]  cfgLow,
  input  logic [CNT_W-1:0]  cfgSetup,
  input  logic [CNT_W-1:0]  cfgLatch,
  output logic              serData,
  output logic [CNT_W-1:0]  lenHigh,
  output logic [CNT_W-1:0]  lenLow,
  output logic [CNT_W-1:0]  lenSetup,
  output logic [CNT_W-1:0]  lenLatch,
  output logic [BIT_W-1:0]  lastBit
);

  localparam int PAD_W = DATA_W - NARROW_W;

  function automatic logic [CNT_W-1:0] atLeast(input logic [CNT_W-1:0] v,
                                               input logic [CNT_W-1:0] floorVal);
    return (v < floorVal) ? floorVal : v;
  endfunction

  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] framedWord;
  logic [CNT_W-1:0]  effHigh, effLow, effSetup, effLatch;

  // left-justify so the frame's first bit is always at the top
  generate
    if (PAD_W > 0) begin : g_pad
      assign framedWord = wideMode ? inData
                                   : {inData[NARROW_W-1:0], {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign framedWord = inData;
    end
  endgenerate

  always_comb begin
    effHigh  = atLeast(cfgHigh,  CNT_W'(MIN_HIGH));
    effSetup = atLeast(cfgSetup, CNT_W'(MIN_SETUP));
    effLow   = atLeast(atLeast(cfgLow, CNT_W'(MIN_LOW)), effSetup);
    effLatch = atLeast(cfgLatch, CNT_W'(MIN_LATCH));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      lenHigh  <= CNT_W'(MIN_HIGH);
      lenSetup <= CNT_W'(MIN_SETUP);
      lenLow   <= atLeast(CNT_W'(MIN_LOW), CNT_W'(MIN_SETUP));
      lenLatch <= CNT_W'(MIN_LATCH);
      lastBit  <= BIT_W'(DATA_W - 1);
    end else if (strobe.load) begin
      shiftReg <= framedWord;
      lenHigh  <= effHigh;
      lenSetup <= effSetup;
      lenLow   <= effLow;
      lenLatch <= effLatch;
      lastBit  <= wideMode ? BIT_W'(DATA_W - 1) : BIT_W'(NARROW_W - 1);
    end else if (strobe.shift) begin
      shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
    end
  end

  assign serData = shiftReg[DATA_W-1];

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.load && strobe.shift)); // R10

  AST_LEN_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    (lenLow >= lenSetup) && (lenHigh >= CNT_W'(MIN_HIGH))
    && (lenLatch >= CNT_W'(MIN_LATCH))); // R7

  AST_SHIFT_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shift |=> $stable(lenHigh) && $stable(lastBit)); // R12

endmodule

// File: rtl/dac_tx_ctrl.sv
module dac_tx_ctrl
  import dac_tx_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int BIT_W     = 5,
  parameter int MIN_HIGH  = 2,
  parameter int MIN_LATCH = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [CNT_W-1:0] lenHigh,
  input  logic [CNT_W-1:0] lenLow,
  input  logic [CNT_W-1:0] lenSetup,
  input  logic [CNT_W-1:0] lenLatch,
  input  logic [BIT_W-1:0] lastBit,
  output dpStrobe_t        strobe,
  output logic             serClk,
  output logic             serLatchN
);

  txState_t         state, nextState;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] phaseLen;
  logic [BIT_W-1:0] bitIdx;
  logic             phaseEnd;

  always_comb begin
    case (state)
      ST_SETUP: phaseLen = lenSetup;
      ST_HIGH:  phaseLen = lenHigh;
      ST_LOW:   phaseLen = lenLow;
      ST_GAP,
      ST_LATCH: phaseLen = lenLatch;
      default:  phaseLen = CNT_W'(1);
    endcase
    phaseEnd = (cnt == phaseLen - CNT_W'(1));
  end

  always_comb begin
    nextState    = state;
    strobe.load  = 1'b0;
    strobe.shift = 1'b0;
    case (state)
      ST_IDLE: if (inValid) begin
        nextState   = ST_SETUP;
        strobe.load = 1'b1;
      end
      ST_SETUP: if (phaseEnd) nextState = ST_HIGH;
      ST_HIGH: if (phaseEnd) begin
        if (bitIdx == lastBit) begin
          nextState = ST_GAP;
        end else begin
          nextState    = ST_LOW;
          strobe.shift = 1'b1;
        end
      end
      ST_LOW:   if (phaseEnd) nextState = ST_HIGH;
      ST_GAP:   if (phaseEnd) nextState = ST_LATCH;
      ST_LATCH: if (phaseEnd) nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
    end else begin
      state <= nextState;
      if (nextState != state) cnt <= '0;
      else if (state != ST_IDLE) cnt <= cnt + CNT_W'(1);
      if (strobe.load) bitIdx <= '0;
      else if (strobe.shift) bitIdx <= bitIdx + BIT_W'(1);
    end
  end

  assign inReady   = (state == ST_IDLE);
  assign serClk    = (state == ST_HIGH);
  assign serLatchN = (state != ST_LATCH);

  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> (serLatchN && !serClk)); // R10

  AST_NO_CLK_IN_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    !serLatchN |-> !serClk); // R9

  AST_EDGE_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    $rose(serClk) |-> (bitIdx <= lastBit)); // R1

  AST_HIGH_MIN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(serClk) |-> (int'($past(cnt)) + 1 >= MIN_HIGH)); // R6

  AST_LATCH_MIN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(serLatchN) |-> (int'($past(cnt)) + 1 >= MIN_LATCH)); // R9

endmodule

// File: rtl/dac_word_tx.sv
module dac_word_tx
  import dac_tx_pkg::*;
#(
  parameter int DATA_W    = 18,
  parameter int NARROW_W  = 16,
  parameter int CNT_W     = 8,
  parameter int MIN_HIGH  = 2,
  parameter int MIN_LOW   = 2,
  parameter int MIN_SETUP = 1,
  parameter int MIN_LATCH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wideMode,
  input  logic [CNT_W-1:0]  cfgHigh,
  input  logic [CNT_W-1:0]  cfgLow,
  input  logic [CNT_W-1:0]  cfgSetup,
  input  logic [CNT_W-1:0]  cfgLatch,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  output logic              serData,
  output logic              serClk,
  output logic              serLatchN
);

  localparam int BIT_W = $clog2(DATA_W);

  dpStrobe_t        strobe;
  logic [CNT_W-1:0] lenHigh, lenLow, lenSetup, lenLatch;
  logic [BIT_W-1:0] lastBit;

  dac_tx_ctrl #(
    .CNT_W(CNT_W), .BIT_W(BIT_W),
    .MIN_HIGH(MIN_HIGH), .MIN_LATCH(MIN_LATCH)
  ) ctrl_i (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .inReady(inReady),
    .lenHigh(lenHigh), .lenLow(lenLow), .lenSetup(lenSetup), .lenLatch(lenLatch),
    .lastBit(lastBit), .strobe(strobe),
    .serClk(serClk), .serLatchN(serLatchN)
  );

  dac_tx_dp #(
    .DATA_W(DATA_W), .NARROW_W(NARROW_W), .CNT_W(CNT_W), .BIT_W(BIT_W),
    .MIN_HIGH(MIN_HIGH), .MIN_LOW(MIN_LOW),
    .MIN_SETUP(MIN_SETUP), .MIN_LATCH(MIN_LATCH)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wideMode(wideMode), .inData(inData),
    .cfgHigh(cfgHigh), .cfgLow(cfgLow), .cfgSetup(cfgSetup), .cfgLatch(cfgLatch),
    .serData(serData),
    .lenHigh(lenHigh), .lenLow(lenLow), .lenSetup(lenSetup), .lenLatch(lenLatch),
    .lastBit(lastBit)
  );

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (serClk && $past(serClk)) |-> $stable(serData)); // R4

endmodule

// File: tb/dac_word_tx_tb.sv
module dac_word_tx_tb_top;

  localparam int DATA_W = 18, NARROW_W = 16, CNT_W = 8;
  localparam int MIN_HIGH = 2, MIN_LOW = 2, MIN_SETUP = 1, MIN_LATCH = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic              wideMode = 1'b1;
  logic [CNT_W-1:0]  cfgHigh = '0, cfgLow = '0, cfgSetup = '0, cfgLatch = '0;
  logic              inValid = 1'b0;
  logic [DATA_W-1:0] inData = '0;
  logic              inReady, serData, serClk, serLatchN;

  dac_word_tx #(
    .DATA_W(DATA_W), .NARROW_W(NARROW_W), .CNT_W(CNT_W),
    .MIN_HIGH(MIN_HIGH), .MIN_LOW(MIN_LOW), .MIN_SETUP(MIN_SETUP), .MIN_LATCH(MIN_LATCH)
  ) dut_i (
    .clk(clk), .rstN(rstN), .wideMode(wideMode),
    .cfgHigh(cfgHigh), .cfgLow(cfgLow), .cfgSetup(cfgSetup), .cfgLatch(cfgLatch),
    .inValid(inValid), .inReady(inReady), .inData(inData),
    .serData(serData), .serClk(serClk), .serLatchN(serLatchN)
  );

  int vectors = 0, fails = 0;
  int expWord, expBits, expHigh, expLow, expSetup, expLat;
  int doneCount = 0;
  bit monOn = 0;
  int cyc = 0;

  function automatic int eff(input int v, input int m);
    return (v < m) ? m : v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL R10 watchdog actual=%0d expected=%0d", doneCount, doneCount + 1);
      finishRun();
    end
  end

  // line monitor: samples away from the active edge
  bit prevClk = 0, prevLatch = 1, prevData = 0;
  int hiLen = 0, loLen = 0, dataAge = 0, latchLen = 0, bitCount = 0, gotWord = 0;

  always @(negedge clk) begin
    if (monOn) begin
      if (serData != prevData) dataAge = 1; else dataAge++;
      if (serClk && !prevClk) begin
        check(dataAge >= expSetup + 1, "R5", dataAge, expSetup + 1);
        if (bitCount > 0) check(loLen == expLow, "R7 R12", loLen, expLow);
        check(!inReady, "R10", inReady, 0);
        gotWord = (gotWord << 1) | int'(serData);
        bitCount++;
        hiLen = 1;
      end else if (serClk) begin
        hiLen++;
        check(serData == prevData, "R4", serData, prevData);
      end
      if (!serClk && prevClk) begin
        check(hiLen == expHigh, "R6 R12", hiLen, expHigh);
        loLen = 1;
      end else if (!serClk) begin
        loLen++;
      end
      if (!serLatchN && prevLatch) begin
        check(loLen - 1 == expLat, "R8", loLen - 1, expLat);
        if (expBits == 18) check(bitCount == 18, "R2", bitCount, 18);
        else               check(bitCount == 16, "R3", bitCount, 16);
        check(gotWord == expWord, "R1", gotWord, expWord);
        latchLen = 1;
      end else if (!serLatchN) begin
        latchLen++;
      end
      if (!serLatchN) check(!serClk && !inReady, "R9", {serClk, inReady}, 0);
      if (serLatchN && !prevLatch) begin
        check(latchLen == expLat, "R9", latchLen, expLat);
        check(inReady, "R10", inReady, 1);
        bitCount = 0;
        gotWord  = 0;
        doneCount++;
      end
      prevClk = serClk; prevLatch = serLatchN; prevData = serData;
    end
  end

  task automatic sendWord(input logic [DATA_W-1:0] d, input bit wide,
                          input int h, input int l, input int s, input int lat,
                          input bit scramble);
    int target;
    @(negedge clk);
    wideMode = wide;
    cfgHigh = CNT_W'(h); cfgLow = CNT_W'(l); cfgSetup = CNT_W'(s); cfgLatch = CNT_W'(lat);
    inData = d;
    inValid = 1'b1;
    while (!inReady) @(negedge clk);
    expWord  = wide ? int'(d) : int'(d[NARROW_W-1:0]);
    expBits  = wide ? 18 : 16;
    expHigh  = eff(h, MIN_HIGH);
    expSetup = eff(s, MIN_SETUP);
    expLow   = eff(eff(l, MIN_LOW), expSetup);
    expLat   = eff(lat, MIN_LATCH);
    target   = doneCount + 1;
    @(posedge clk);
    #1;
    inValid = 1'b0;
    if (scramble) begin
      // R12: changes after acceptance must not reach this frame
      wideMode = ~wide;
      cfgHigh  = CNT_W'($urandom_range(0, 9));
      cfgLow   = CNT_W'($urandom_range(0, 9));
      cfgSetup = CNT_W'($urandom_range(0, 9));
      cfgLatch = CNT_W'($urandom_range(0, 9));
      inData   = DATA_W'($urandom);
    end
    while (doneCount < target) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check(serLatchN == 1'b1, "R11", serLatchN, 1);
    check(serClk == 1'b0, "R11", serClk, 0);
    check(inReady == 1'b1, "R11", inReady, 1);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(serData == 1'b0, "R11", serData, 0);
    check(serLatchN && !serClk && inReady, "R11", {serLatchN, serClk, inReady}, 3'b101);
    prevClk = serClk; prevLatch = serLatchN; prevData = serData;
    monOn = 1;

    // directed corners
    sendWord(18'h3FFFF, 1, 0, 0, 0, 0, 0);   // all counts clamped
    sendWord(18'h30000, 0, 1, 1, 0, 1, 0);   // R3 upper junk, zero payload
    sendWord(18'h3A5A5, 0, 3, 2, 6, 3, 1);   // R7 setup stretches low
    sendWord(18'h20001, 1, 4, 5, 2, 5, 1);
    sendWord(18'h15555, 1, 2, 2, 1, 2, 0);
    sendWord(18'h18001, 0, 7, 3, 3, 4, 1);
    for (int i = 0; i < 40; i++) begin
      sendWord(DATA_W'($urandom), 1'($urandom_range(0, 1)),
               $urandom_range(0, 6), $urandom_range(0, 6),
               $urandom_range(0, 6), $urandom_range(0, 6),
               1'($urandom_range(0, 1)));
    end
    repeat (3) @(negedge clk);
    check(serLatchN && !serClk && inReady, "R11", {serLatchN, serClk, inReady}, 3'b101);
    finishRun();
  end

endmodule